// File: doc/BRIEF.md
# I2C Register Front End with Command and Receive FIFOs

This block is the memory-mapped register side of an I2C master. Software writes command words (a data byte plus start and stop flags) into a command FIFO, which the bit engine drains one word at a time. Bytes the engine receives are pushed into a receive FIFO, and software reads them out through a data register. Each read of that register removes the byte it returns.

The block also holds the control word, the three SCL/SDA timing counts and the interrupt enable mask. The interrupt status word has two parts. Two ready flags are live comparisons of the FIFO fill levels against programmable thresholds. Three sticky event flags (missing acknowledge, lost arbitration, receive overflow) are cleared by writing ones. A single interrupt line is raised while any enabled status bit is set.

Registers sit on 32-bit word boundaries. The byte offsets are: 0x00 command, 0x04 receive data, 0x08 control, 0x0C interrupt enable, 0x10 interrupt status, 0x14 engine status, 0x18 command fill level, 0x1C receive fill level, 0x20 SCL low count, 0x24 SCL high count, 0x28 SDA hold count.

Top module: `i2c_reg_front`

## Requirements
- R1: Control (0x08, bits 5:0), interrupt enable (0x0C, bits 4:0) and the three timing counts (0x20 low, 0x24 high, 0x28 hold, CNT_W bits) read back what was last written. The counts also drive `sclLowCnt`, `sclHighCnt` and `sdaHoldCnt`. All of them reset to 0.
- R2: While enabled, a write to 0x00 queues bits 9:0 of the data: bit 9 is start, bit 8 is stop, bits 7:0 are the byte. `cmdValid` is high while the queue is non-empty, and `cmdData` shows the oldest entry. A cycle with `cmdPopReq` high removes that entry. 0x18 returns the entry count.
- R3: A command write while the queue holds FIFO_DEPTH entries, with no pop in the same cycle, is ignored.
- R4: While enabled, `rxPush` queues `rxByte`. A read of 0x04 returns the oldest byte in bits 7:0 and removes it. A read of 0x04 on an empty queue returns 0 and changes nothing. 0x1C returns the entry count.
- R5: A push to a full receive queue with no same-cycle read of 0x04 drops the byte and sets status bit 4 (overflow). A push in the same cycle as a read is accepted and raises no overflow.
- R6: Status bit 0 (TX ready) is 1 exactly while the command count is at most control bits 3:2.
- R7: Status bit 1 (RX ready) is 1 exactly while the receive count is greater than control bits 5:4, so a threshold of 0 means one entry.
- R8: Status bits 2 (no acknowledge) and 3 (arbitration lost) are set by `evNack` and `evArbLost`. Bits 2..4 are cleared by writing 1 to 0x10. An event in the same cycle as its clear leaves the bit set. Writing to bits 0 and 1 has no effect.
- R9: `irq` is 1 exactly while the status word ANDed with the enable mask is non-zero.
- R10: While control bit 0 (enable) is 0, both queues are emptied on every clock edge. Command writes and receive pushes are lost, and no overflow is raised.
- R11: 0x14 bit 0 returns `coreBusy`. `coreEnable` and `fastMode` follow control bits 0 and 1.
- R12: `regRdData` loads the addressed register on the clock edge where `regRdEn` is high and holds otherwise. Offsets above 0x28 and the command offset read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | ADDR_W (6) | Byte address |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Registered read data |
| irq | output | 1 | Interrupt request |
| coreEnable | output | 1 | Control enable bit |
| fastMode | output | 1 | Control fast-speed bit |
| sclLowCnt | output | CNT_W (16) | SCL low count |
| sclHighCnt | output | CNT_W (16) | SCL high count |
| sdaHoldCnt | output | CNT_W (16) | SDA hold count |
| cmdPopReq | input | 1 | Engine takes the head command |
| cmdValid | output | 1 | Command queue non-empty |
| cmdData | output | 10 | Head command word |
| rxPush | input | 1 | Engine delivers a received byte |
| rxByte | input | 8 | Received byte |
| evNack | input | 1 | No-acknowledge event strobe |
| evArbLost | input | 1 | Arbitration-lost event strobe |
| coreBusy | input | 1 | Engine busy flag |

## Verification
Two pairs of functions can land in the same cycle. The first pair is an engine push into a full receive queue together with a software read of 0x04. The bench provokes it by filling the queue to four entries and then raising `rxPush` in the same cycle as the read. It checks that the old head is returned, the count stays at four and no overflow bit appears. The second pair is an event strobe together with a write-1-to-clear of the same bit; the bit must read back as set afterwards. A behavioural queue model, compared on every clock, also meets both collisions at random during a long mixed run, along with command pushes that coincide with engine pops.

// File: rtl/i2c_reg_pkg.sv
package i2c_reg_pkg;

  localparam int CTRL_W     = 6;
  localparam int CTL_EN     = 0;
  localparam int CTL_FAST   = 1;
  localparam int CTL_CTHR   = 2;   // command threshold, 2 bits
  localparam int CTL_RTHR   = 4;   // receive threshold, 2 bits
  localparam int IRQ_W      = 5;
  localparam int IRQ_TXRDY  = 0;
  localparam int IRQ_RXRDY  = 1;
  localparam int IRQ_NACK   = 2;   // sticky bits start here
  localparam int STICKY_N   = 3;
  localparam int CMD_W      = 10;
  localparam int DATA_W     = 32;

  typedef enum logic [3:0] {
    SEL_CMD    = 4'd0,
    SEL_RXDATA = 4'd1,
    SEL_CTRL   = 4'd2,
    SEL_IEN    = 4'd3,
    SEL_IST    = 4'd4,
    SEL_STAT   = 4'd5,
    SEL_CMDLVL = 4'd6,
    SEL_RXLVL  = 4'd7,
    SEL_SCLLO  = 4'd8,
    SEL_SCLHI  = 4'd9,
    SEL_HOLD   = 4'd10,
    SEL_NONE   = 4'd15
  } regSel_e;

  typedef struct packed {
    logic    cmdPush;
    logic    rxPop;
    logic    ctrlWr;
    logic    ienWr;
    logic    istClr;
    logic    sclLoWr;
    logic    sclHiWr;
    logic    holdWr;
    logic    rdLatch;
    regSel_e rdSel;
  } regStrobe_t;

endpackage

// File: rtl/i2c_reg_fifo.sv
module i2c_reg_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic [LVL_W-1:0] level,
  output logic             full,
  output logic             empty,
  output logic             pushTaken,
  output logic             popTaken
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full      = (level == LVL_W'(DEPTH));
  assign empty     = (level == '0);
  assign popTaken  = pop && !empty && !flush;
  assign pushTaken = push && (!full || popTaken) && !flush;
  assign dout      = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (pushTaken) mem[wrPtr] <= din;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else if (flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (pushTaken) wrPtr <= nextPtr(wrPtr);
      if (popTaken)  rdPtr <= nextPtr(rdPtr);
      level <= level + LVL_W'(pushTaken) - LVL_W'(popTaken);
    end
  end

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    level <= LVL_W'(DEPTH)); // R2
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> empty); // R10

endmodule

// File: rtl/i2c_reg_ctrl.sv
module i2c_reg_ctrl
  import i2c_reg_pkg::*;
#(
  parameter int ADDR_W = 6,
  localparam int WORD_W = ADDR_W - 2
) (
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  output regStrobe_t        strb
);

  logic [WORD_W-1:0] wordIdx;
  logic              inRange;
  regSel_e           sel;

  assign wordIdx = regAddr[ADDR_W-1:2];
  assign inRange = (wordIdx <= WORD_W'(SEL_HOLD));
  assign sel     = inRange ? regSel_e'(wordIdx[3:0]) : SEL_NONE;

  always_comb begin
    strb         = '0;
    strb.rdSel   = sel;
    strb.rdLatch = regRdEn;
    strb.rxPop   = regRdEn && (sel == SEL_RXDATA);
    if (regWrEn) begin
      case (sel)
        SEL_CMD:   strb.cmdPush = 1'b1;
        SEL_CTRL:  strb.ctrlWr  = 1'b1;
        SEL_IEN:   strb.ienWr   = 1'b1;
        SEL_IST:   strb.istClr  = 1'b1;
        SEL_SCLLO: strb.sclLoWr = 1'b1;
        SEL_SCLHI: strb.sclHiWr = 1'b1;
        SEL_HOLD:  strb.holdWr  = 1'b1;
        default:   ;
      endcase
    end
  end

endmodule

// File: rtl/i2c_reg_dpath.sv
module i2c_reg_dpath
  import i2c_reg_pkg::*;
#(
  parameter int FIFO_DEPTH = 4,
  parameter int CNT_W      = 16,
  localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              cmdPopReq,
  input  logic              rxPush,
  input  logic [7:0]        rxByte,
  input  logic              evNack,
  input  logic              evArbLost,
  input  logic              coreBusy,
  output logic              cmdValid,
  output logic [CMD_W-1:0]  cmdData,
  output logic [DATA_W-1:0] rdData,
  output logic              irq,
  output logic              coreEnable,
  output logic              fastMode,
  output logic [CNT_W-1:0]  sclLowCnt,
  output logic [CNT_W-1:0]  sclHighCnt,
  output logic [CNT_W-1:0]  sdaHoldCnt
);

  logic [CTRL_W-1:0]   ctrlQ;
  logic [IRQ_W-1:0]    ienQ;
  logic [STICKY_N-1:0] stickyQ;
  logic [STICKY_N-1:0] evIn;
  logic [CNT_W-1:0]    loQ, hiQ, holdQ;
  logic [DATA_W-1:0]   rdQ, rdMux;
  logic [IRQ_W-1:0]    istVec;
  logic                ctrlEn, flush;

  logic [LVL_W-1:0]    cmdLevel, rxLevel;
  logic                cmdFull, cmdEmpty, cmdPushTaken, cmdPopTaken;
  logic                rxFull, rxEmpty, rxPushTaken, rxPopTaken;
  logic [7:0]          rxHead;
  logic                txReady, rxReady, ovfEvent;

  assign ctrlEn = ctrlQ[CTL_EN];
  assign flush  = !ctrlEn;

  i2c_reg_fifo #(.WIDTH(CMD_W), .DEPTH(FIFO_DEPTH)) u_cmdFifo (
    .clk(clk), .rstN(rstN), .flush(flush),
    .push(strb.cmdPush), .pop(cmdPopReq), .din(wrData[CMD_W-1:0]),
    .dout(cmdData), .level(cmdLevel), .full(cmdFull), .empty(cmdEmpty),
    .pushTaken(cmdPushTaken), .popTaken(cmdPopTaken)
  );

  i2c_reg_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_rxFifo (
    .clk(clk), .rstN(rstN), .flush(flush),
    .push(rxPush), .pop(strb.rxPop), .din(rxByte),
    .dout(rxHead), .level(rxLevel), .full(rxFull), .empty(rxEmpty),
    .pushTaken(rxPushTaken), .popTaken(rxPopTaken)
  );

  assign cmdValid = !cmdEmpty;
  assign txReady  = (int'(cmdLevel) <= int'(ctrlQ[CTL_CTHR +: 2]));
  assign rxReady  = (int'(rxLevel) > int'(ctrlQ[CTL_RTHR +: 2]));
  assign ovfEvent = rxPush && rxFull && !rxPopTaken && ctrlEn;

  // Sticky event bits: index 0 no-ack, 1 arbitration, 2 overflow.
  assign evIn = {ovfEvent, evArbLost, evNack};

  for (genvar i = 0; i < STICKY_N; i++) begin : g_sticky
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stickyQ[i] <= 1'b0;
      else       stickyQ[i] <= (stickyQ[i] && !(strb.istClr && wrData[IRQ_NACK + i]))
                               || evIn[i];
    end
  end

  assign istVec = {stickyQ, rxReady, txReady};
  assign irq    = |(istVec & ienQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ <= '0;
      ienQ  <= '0;
      loQ   <= '0;
      hiQ   <= '0;
      holdQ <= '0;
    end else begin
      if (strb.ctrlWr)  ctrlQ <= wrData[CTRL_W-1:0];
      if (strb.ienWr)   ienQ  <= wrData[IRQ_W-1:0];
      if (strb.sclLoWr) loQ   <= wrData[CNT_W-1:0];
      if (strb.sclHiWr) hiQ   <= wrData[CNT_W-1:0];
      if (strb.holdWr)  holdQ <= wrData[CNT_W-1:0];
    end
  end

  always_comb begin
    rdMux = '0;
    case (strb.rdSel)
      SEL_RXDATA: rdMux = rxEmpty ? '0 : DATA_W'(rxHead);
      SEL_CTRL:   rdMux = DATA_W'(ctrlQ);
      SEL_IEN:    rdMux = DATA_W'(ienQ);
      SEL_IST:    rdMux = DATA_W'(istVec);
      SEL_STAT:   rdMux = DATA_W'(coreBusy);
      SEL_CMDLVL: rdMux = DATA_W'(cmdLevel);
      SEL_RXLVL:  rdMux = DATA_W'(rxLevel);
      SEL_SCLLO:  rdMux = DATA_W'(loQ);
      SEL_SCLHI:  rdMux = DATA_W'(hiQ);
      SEL_HOLD:   rdMux = DATA_W'(holdQ);
      default:    rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             rdQ <= '0;
    else if (strb.rdLatch) rdQ <= rdMux;
  end

  assign rdData     = rdQ;
  assign coreEnable = ctrlEn;
  assign fastMode   = ctrlQ[CTL_FAST];
  assign sclLowCnt  = loQ;
  assign sclHighCnt = hiQ;
  assign sdaHoldCnt = holdQ;

  AST_RX_DROP_KEEPS_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    (rxPush && rxFull && !strb.rxPop && ctrlEn) |=> (rxLevel == LVL_W'(FIFO_DEPTH))); // R5
  AST_RX_DROP_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    (rxPush && rxFull && !strb.rxPop && ctrlEn) |=> istVec[IRQ_NACK + 2]); // R5
  AST_CMD_FULL_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (strb.cmdPush && cmdFull && !cmdPopReq && ctrlEn) |=> $stable(cmdLevel)); // R3
  AST_RX_READ_POPS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rxPop && !rxEmpty && !rxPush && ctrlEn) |=> (rxLevel == $past(rxLevel) - LVL_W'(1))); // R4
  AST_NACK_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    evNack |=> istVec[IRQ_NACK]); // R8
  AST_ARB_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    evArbLost |=> istVec[IRQ_NACK + 1]); // R8
  AST_NO_PUSH_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlEn |-> !(cmdPushTaken || rxPushTaken)); // R10

endmodule

// File: rtl/i2c_reg_front.sv
module i2c_reg_front
  import i2c_reg_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int FIFO_DEPTH = 4,
  parameter int CNT_W      = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  output logic              irq,
  output logic              coreEnable,
  output logic              fastMode,
  output logic [CNT_W-1:0]  sclLowCnt,
  output logic [CNT_W-1:0]  sclHighCnt,
  output logic [CNT_W-1:0]  sdaHoldCnt,
  input  logic              cmdPopReq,
  output logic              cmdValid,
  output logic [9:0]        cmdData,
  input  logic              rxPush,
  input  logic [7:0]        rxByte,
  input  logic              evNack,
  input  logic              evArbLost,
  input  logic              coreBusy
);

  regStrobe_t strb;

  i2c_reg_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr), .strb(strb)
  );

  i2c_reg_dpath #(.FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(regWrData),
    .cmdPopReq(cmdPopReq), .rxPush(rxPush), .rxByte(rxByte),
    .evNack(evNack), .evArbLost(evArbLost), .coreBusy(coreBusy),
    .cmdValid(cmdValid), .cmdData(cmdData), .rdData(regRdData), .irq(irq),
    .coreEnable(coreEnable), .fastMode(fastMode),
    .sclLowCnt(sclLowCnt), .sclHighCnt(sclHighCnt), .sdaHoldCnt(sdaHoldCnt)
  );

endmodule

// File: tb/i2c_reg_front_tb.sv
`timescale 1ns/1ps
module i2c_reg_front_tb;

  localparam int D  = 4;
  localparam int CW = 16;

  logic        clk = 1'b0;
  logic        rstN;
  logic        regWrEn, regRdEn;
  logic [5:0]  regAddr;
  logic [31:0] regWrData, regRdData;
  logic        irq, coreEnable, fastMode;
  logic [CW-1:0] sclLowCnt, sclHighCnt, sdaHoldCnt;
  logic        cmdPopReq, cmdValid;
  logic [9:0]  cmdData;
  logic        rxPush;
  logic [7:0]  rxByte;
  logic        evNack, evArbLost, coreBusy;

  int checks = 0;
  int errors = 0;
  bit running = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  i2c_reg_front #(.ADDR_W(6), .FIFO_DEPTH(D), .CNT_W(CW)) u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .irq(irq), .coreEnable(coreEnable), .fastMode(fastMode),
    .sclLowCnt(sclLowCnt), .sclHighCnt(sclHighCnt), .sdaHoldCnt(sdaHoldCnt),
    .cmdPopReq(cmdPopReq), .cmdValid(cmdValid), .cmdData(cmdData),
    .rxPush(rxPush), .rxByte(rxByte), .evNack(evNack), .evArbLost(evArbLost),
    .coreBusy(coreBusy)
  );

  // ---------------- behavioural reference model ----------------
  logic [9:0]  mCmd[$];
  logic [7:0]  mRx[$];
  logic [5:0]  mCtrl;
  logic [4:0]  mIen;
  bit          mNack, mArb, mOvf;
  logic [CW-1:0] mLo, mHi, mHold;
  logic [31:0] mRd;

  function automatic logic [4:0] mIst();
    logic [4:0] s;
    s[0] = (mCmd.size() <= int'(mCtrl[3:2]));
    s[1] = (mRx.size() > int'(mCtrl[5:4]));
    s[2] = mNack;
    s[3] = mArb;
    s[4] = mOvf;
    return s;
  endfunction

  function automatic logic [31:0] mRead(input int w);
    case (w)
      1:  return (mRx.size() > 0) ? 32'(mRx[0]) : 32'd0;
      2:  return 32'(mCtrl);
      3:  return 32'(mIen);
      4:  return 32'(mIst());
      5:  return 32'(coreBusy);
      6:  return 32'(mCmd.size());
      7:  return 32'(mRx.size());
      8:  return 32'(mLo);
      9:  return 32'(mHi);
      10: return 32'(mHold);
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin : model
    int  w, cs, rs;
    bit  en, cPop, rPop, ovfEv, clr;
    logic [31:0] rv;
    if (!rstN) begin
      mCmd.delete(); mRx.delete();
      mCtrl = '0; mIen = '0; mNack = 0; mArb = 0; mOvf = 0;
      mLo = '0; mHi = '0; mHold = '0; mRd = '0;
    end else begin
      w  = int'(regAddr[5:2]);
      en = mCtrl[0];
      cs = mCmd.size();
      rs = mRx.size();
      rv = mRead(w);
      cPop  = cmdPopReq && cs > 0;
      rPop  = regRdEn && w == 1 && rs > 0;
      ovfEv = en && rxPush && rs == D && !rPop;
      clr   = regWrEn && w == 4;
      if (regRdEn) mRd = rv;
      if (!en) begin
        mCmd.delete(); mRx.delete();
      end else begin
        if (cPop) void'(mCmd.pop_front());
        if (regWrEn && w == 0 && (cs < D || cPop)) mCmd.push_back(regWrData[9:0]);
        if (rPop) void'(mRx.pop_front());
        if (rxPush && (rs < D || rPop)) mRx.push_back(rxByte);
      end
      mNack = (mNack && !(clr && regWrData[2])) || evNack;
      mArb  = (mArb  && !(clr && regWrData[3])) || evArbLost;
      mOvf  = (mOvf  && !(clr && regWrData[4])) || ovfEv;
      if (regWrEn) begin
        case (w)
          2:  mCtrl = regWrData[5:0];
          3:  mIen  = regWrData[4:0];
          8:  mLo   = regWrData[CW-1:0];
          9:  mHi   = regWrData[CW-1:0];
          10: mHold = regWrData[CW-1:0];
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && running) begin
      chk("R9 irq", 32'(irq), 32'(|(mIst() & mIen)));
      chk("R2 cmdValid", 32'(cmdValid), 32'(mCmd.size() > 0));
      if (mCmd.size() > 0) chk("R2 cmdData", 32'(cmdData), 32'(mCmd[0]));
      chk("R11 coreEnable", 32'(coreEnable), 32'(mCtrl[0]));
      chk("R11 fastMode", 32'(fastMode), 32'(mCtrl[1]));
      chk("R1 sclLowCnt", 32'(sclLowCnt), 32'(mLo));
      chk("R1 sclHighCnt", 32'(sclHighCnt), 32'(mHi));
      chk("R1 sdaHoldCnt", 32'(sdaHoldCnt), 32'(mHold));
      chk("R12 regRdData", regRdData, mRd);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    regWrEn = 1; regAddr = a; regWrData = d;
    step();
    regWrEn = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] v);
    regRdEn = 1; regAddr = a;
    step();
    regRdEn = 0;
    v = regRdData;
  endtask

  task automatic pushRx(input logic [7:0] b);
    rxPush = 1; rxByte = b;
    step();
    rxPush = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired before stimulus ended");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    rstN = 0; regWrEn = 0; regRdEn = 0; regAddr = '0; regWrData = '0;
    cmdPopReq = 0; rxPush = 0; rxByte = '0; evNack = 0; evArbLost = 0; coreBusy = 0;
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    running = 1;

    // reset state
    rd(6'h10, v); chk("R6 reset status", v, 32'h01);
    rd(6'h08, v); chk("R1 reset control", v, 32'h00);
    rd(6'h18, v); chk("R2 reset cmd level", v, 32'h0);
    chk("R9 reset irq", 32'(irq), 32'h0);

    // enable, unmask all
    wr(6'h08, 32'h01);
    wr(6'h0C, 32'h1F);
    chk("R9 irq from tx ready", 32'(irq), 32'h1);

    // command fill and overfill
    wr(6'h00, 32'h2A5); wr(6'h00, 32'h011); wr(6'h00, 32'h122); wr(6'h00, 32'h033);
    wr(6'h00, 32'h0FF);
    rd(6'h18, v); chk("R3 full write ignored", v, 32'd4);
    rd(6'h10, v); chk("R6 tx ready low at level 4", v & 32'h1, 32'h0);
    chk("R2 head start+byte", 32'(cmdData), 32'h2A5);
    cmdPopReq = 1;
    step(); chk("R2 order 2", 32'(cmdData), 32'h011);
    step(); chk("R2 order 3", 32'(cmdData), 32'h122);
    step(); chk("R2 order 4 stop", 32'(cmdData), 32'h033);
    step(); cmdPopReq = 0;
    chk("R2 drained", 32'(cmdValid), 32'h0);

    // thresholds: cmd thr 2, rx thr 1
    wr(6'h08, 32'h19);
    wr(6'h00, 32'h001); wr(6'h00, 32'h002);
    rd(6'h10, v); chk("R6 level 2 thr 2", v & 32'h1, 32'h1);
    wr(6'h00, 32'h003);
    rd(6'h10, v); chk("R6 level 3 thr 2", v & 32'h1, 32'h0);

    pushRx(8'hA1);
    rd(6'h10, v); chk("R7 rx level 1 thr 1", v & 32'h2, 32'h0);
    pushRx(8'hB2);
    rd(6'h10, v); chk("R7 rx level 2 thr 1", v & 32'h2, 32'h2);
    pushRx(8'hC3); pushRx(8'hD4); pushRx(8'hE5);
    rd(6'h10, v); chk("R5 overflow flagged", v, 32'h12);
    rd(6'h1C, v); chk("R5 dropped byte", v, 32'd4);
    wr(6'h10, 32'h10);
    rd(6'h10, v); chk("R8 overflow cleared", v, 32'h02);

    // collision: push into full queue with read
    rxPush = 1; rxByte = 8'hF6;
    rd(6'h04, v);
    rxPush = 0;
    chk("R4 read head during push", v, 32'hA1);
    rd(6'h1C, v); chk("R5 push accepted with read", v, 32'd4);
    rd(6'h10, v); chk("R5 no overflow on collision", v, 32'h02);
    rd(6'h04, v); chk("R4 byte 2", v, 32'hB2);
    rd(6'h04, v); chk("R4 byte 3", v, 32'hC3);
    rd(6'h04, v); chk("R4 byte 4", v, 32'hD4);
    rd(6'h04, v); chk("R4 byte 5", v, 32'hF6);
    rd(6'h04, v); chk("R4 empty read", v, 32'h0);
    rd(6'h1C, v); chk("R4 empty level", v, 32'h0);

    // sticky events
    evNack = 1; step(); evNack = 0;
    rd(6'h10, v); chk("R8 nack set", v, 32'h04);
    evArbLost = 1; step(); evArbLost = 0;
    rd(6'h10, v); chk("R8 arb set", v, 32'h0C);
    wr(6'h10, 32'h0B);
    rd(6'h10, v); chk("R8 arb clear, live bits untouched", v, 32'h04);
    evNack = 1; wr(6'h10, 32'h04); evNack = 0;
    rd(6'h10, v); chk("R8 set beats clear", v, 32'h04);
    wr(6'h10, 32'h04);
    rd(6'h10, v); chk("R8 cleared", v, 32'h00);
    chk("R9 irq low with nothing pending", 32'(irq), 32'h0);
    wr(6'h0C, 32'h00);
    evArbLost = 1; step(); evArbLost = 0;
    chk("R9 masked event", 32'(irq), 32'h0);
    wr(6'h0C, 32'h08);
    chk("R9 unmasked event", 32'(irq), 32'h1);
    wr(6'h10, 32'h08);

    // disable flushes
    pushRx(8'h5A);
    wr(6'h08, 32'h18);
    step();
    rd(6'h18, v); chk("R10 cmd flushed", v, 32'h0);
    rd(6'h1C, v); chk("R10 rx flushed", v, 32'h0);
    wr(6'h00, 32'h055);
    pushRx(8'h66);
    rd(6'h18, v); chk("R10 cmd write while off", v, 32'h0);
    rd(6'h1C, v); chk("R10 rx push while off", v, 32'h0);
    rd(6'h10, v); chk("R10 status while off", v, 32'h01);

    // status and control outputs
    coreBusy = 1;
    rd(6'h14, v); chk("R11 busy", v, 32'h1);
    coreBusy = 0;
    rd(6'h14, v); chk("R11 idle", v, 32'h0);
    wr(6'h08, 32'h03);
    chk("R11 fast", 32'(fastMode), 32'h1);
    chk("R11 enable", 32'(coreEnable), 32'h1);

    // timing counts and unmapped reads
    wr(6'h20, 32'h1234); wr(6'h24, 32'hFFFF_ABCD); wr(6'h28, 32'h77);
    chk("R1 low out", 32'(sclLowCnt), 32'h1234);
    chk("R1 high out", 32'(sclHighCnt), 32'hABCD);
    rd(6'h28, v); chk("R1 hold read", v, 32'h77);
    step(); step();
    chk("R12 read data held", regRdData, 32'h77);
    rd(6'h2C, v); chk("R12 unmapped", v, 32'h0);
    rd(6'h3C, v); chk("R12 unmapped top", v, 32'h0);
    rd(6'h00, v); chk("R12 command reads zero", v, 32'h0);

    // mixed random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] d;
      d = $urandom;
      regAddr   = 6'($urandom_range(0, 11) * 4);
      if (regAddr == 6'h08 && ($urandom % 10) != 0) d[0] = 1'b1;
      regWrData = d;
      regWrEn   = ($urandom % 3) == 0;
      regRdEn   = ($urandom % 3) == 0;
      cmdPopReq = ($urandom % 3) == 0;
      rxPush    = ($urandom % 3) == 0;
      rxByte    = 8'($urandom);
      evNack    = ($urandom % 16) == 0;
      evArbLost = ($urandom % 16) == 0;
      coreBusy  = 1'($urandom);
      if (regAddr == 6'h00 || regAddr == 6'h04) begin
        if (($urandom % 2) == 0) regWrData[0] = 1'b0;
      end
      step();
    end
    regWrEn = 0; regRdEn = 0; cmdPopReq = 0; rxPush = 0; evNack = 0; evArbLost = 0;
    step(); step();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule